// File: doc/BRIEF.md
# Supply Protection Supervisor

This block sequences the supply of a switched-mode power controller. Comparators outside the block turn each supply, line, feedback and thermistor condition into a digital flag. The supervisor uses these flags to decide when the high-voltage startup current charges the supply capacitor, when the PWM stage may switch, and when the chip drops into a low-current protection state. A free-running timebase pulse (`tick`) drives four fault debounce timers: feedback overload, supply over-voltage, slow thermistor over-temperature and fast thermistor latch.

The stop level is two-level. With no fault present, switching runs until the supply falls below the normal lockout level. Once a fault is caught, switching stops at once, and the supply level that ends the fault phase rises to the 11 V level. Below that level the chip draws little current, so the capacitor discharges slowly. From there it recharges from the 7 V level up to the 17 V level.

Faults come in two kinds:
- An auto-restart fault is forgotten at the 11 V level, so the next 17 V crossing resumes switching.
- A latched fault survives every recharge cycle and is dropped only when the supply collapses below the 4 V level.

A configuration pin chooses which of the two kinds an overload is.

Top module: `supply_supervisor`

## Requirements
- R1: After reset the block is in startup: `pwmRun`=0, `protMode`=0, `faultStatus`=0, and `hvStartEn`=1 while `vddAboveOn` is low. Switching (`pwmRun`=1, `hvStartEn`=0) begins one clock edge after `vddAboveOn`, `vddAboveAc` and `lineOk` are all high. If any of them is low, switching does not begin.
- R2: With no fault, `pwmRun` stays high while `vddAboveUvlo` is high, including below the 11 V level. It falls one edge after `vddAboveUvlo` goes low, and the block then returns to startup.
- R3: While switching, `lineOk` going low stops switching on the next edge and returns the block to startup.
- R4: Each fault timer advances by one on every edge where both its condition and `tick` are high. Its fault fires when the count reaches its limit. The count restarts from zero whenever the condition is low. The overload timer counts only while switching. A condition that first holds at edge 1 stops switching at edge LIMIT+1.
- R5: A fired fault stops switching on the next edge and sets `faultStatus`. The bits are: bit0 overload, bit1 supply over-voltage, bit2 slow over-temperature, bit3 fast thermistor latch. After that, `hvStartEn` and `protMode` stay low while `vddAboveOff` is high.
- R6: In a fault, `protMode` rises one edge after `vddAboveOff` goes low. On that same edge, an auto-restart fault clears `faultStatus` to 0.
- R7: In protection mode, `hvStartEn` rises one edge after `vddAboveRestart` goes low and falls one edge after `vddAboveOn` goes high.
- R8: For an auto-restart fault, the first `vddAboveOn` rise after recharge resumes switching, with `protMode`=0.
- R9: For a latched fault, a `vddAboveOn` rise turns `hvStartEn` off without switching. `protMode` stays 1 and `faultStatus` is kept, and this repeats on every recharge cycle.
- R10: In any fault state, `vddAboveRelease` going low clears `faultStatus` and returns the block to startup (`protMode`=0) on the next edge. A later start then proceeds as in R1.
- R11: With `latchOverload`=1 an overload is latched; with 0 it is auto-restart. Over-voltage and both thermistor faults are always latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase pulse that advances the debounce timers |
| vddAboveOn | input | 1 | Supply at or above the 17 V start level |
| vddAboveOff | input | 1 | Supply at or above the 11 V fault-stop level |
| vddAboveRestart | input | 1 | Supply at or above the 7 V recharge level |
| vddAboveUvlo | input | 1 | Supply at or above the 6.5 V normal lockout level |
| vddAboveRelease | input | 1 | Supply at or above the 4 V latch-release level |
| vddAboveAc | input | 1 | Supply above the brown-in supply level (lockout + 3 V) |
| vddOverVolt | input | 1 | Supply above the over-voltage level |
| lineOk | input | 1 | Line above brown-in level (low means brownout) |
| fbOverload | input | 1 | Feedback above the overload level |
| rtBelowTemp | input | 1 | Thermistor pin below the over-temperature level |
| rtBelowLatch | input | 1 | Thermistor pin below the fast latch level |
| latchOverload | input | 1 | 1: overload is latched, 0: auto-restart |
| hvStartEn | output | 1 | High-voltage startup current enable |
| pwmRun | output | 1 | PWM switching enable |
| protMode | output | 1 | Low-current protection mode |
| faultStatus | output | 4 | Cause of the current fault, one bit per fault |

## Verification
Every threshold reaction shows on the outputs one clock edge after the flag changes, because the state register is the only stage on that path. A fault condition held from edge 1 fires its timer at edge LIMIT and stops switching at edge LIMIT+1. The bench changes inputs on falling edges and then waits exactly the computed number of rising edges before sampling at the next falling edge. For each fault it checks one edge before the due edge (still switching) and the due edge itself (stopped), which pins the latency exactly.

// File: rtl/supv_pkg.sv
package supv_pkg;
  localparam int NFAULT      = 4;
  localparam int F_OVERLOAD  = 0;
  localparam int F_OVERVOLT  = 1;
  localparam int F_TEMP      = 2;
  localparam int F_EXTLATCH  = 3;

  typedef enum logic [2:0] {
    ST_STARTUP,
    ST_RUN,
    ST_FAULT_HI,
    ST_PROT_LOW,
    ST_PROT_CHG
  } state_e;

  typedef struct packed {
    logic overloadArm;
    logic clearAll;
  } strobe_t;
endpackage

// File: rtl/supv_debounce.sv
module supv_debounce #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick,
  input  logic cond,
  output logic trip
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   cnt <= '0;
    else if (!cond)              cnt <= '0;
    else if (tick && cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign trip = (cnt == LIM);

  assert_count_cap_R4: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= LIM);
  assert_trip_needs_cond_R4: assert property (@(posedge clk) disable iff (!rstN)
    trip |-> $past(cond));
endmodule

// File: rtl/supv_timers.sv
module supv_timers
  import supv_pkg::*;
#(
  parameter int unsigned OVERLOAD_TICKS = 57500,
  parameter int unsigned OVERVOLT_TICKS = 205,
  parameter int unsigned TEMP_TICKS     = 14500,
  parameter int unsigned EXTLATCH_TICKS = 185
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic [NFAULT-1:0] condVec,
  input  strobe_t           strobe,
  output logic [NFAULT-1:0] tripVec
);
  localparam int unsigned LIMS [NFAULT] =
    '{OVERLOAD_TICKS, OVERVOLT_TICKS, TEMP_TICKS, EXTLATCH_TICKS};

  for (genvar g = 0; g < NFAULT; g++) begin : g_timer
    logic armed;
    if (g == F_OVERLOAD) begin : g_arm
      assign armed = condVec[g] && strobe.overloadArm && !strobe.clearAll;
    end else begin : g_free
      assign armed = condVec[g] && !strobe.clearAll;
    end
    supv_debounce #(.LIMIT(LIMS[g])) u_deb (
      .clk (clk),
      .rstN(rstN),
      .tick(tick),
      .cond(armed),
      .trip(tripVec[g])
    );
  end
endmodule

// File: rtl/supv_ctrl.sv
module supv_ctrl
  import supv_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              vddAboveOn,
  input  logic              vddAboveOff,
  input  logic              vddAboveRestart,
  input  logic              vddAboveUvlo,
  input  logic              vddAboveRelease,
  input  logic              vddAboveAc,
  input  logic              lineOk,
  input  logic              latchOverload,
  input  logic [NFAULT-1:0] tripVec,
  output strobe_t           strobe,
  output logic              hvStartEn,
  output logic              pwmRun,
  output logic              protMode,
  output logic [NFAULT-1:0] faultStatus
);
  state_e state, nextState;
  logic [NFAULT-1:0] faultQ;
  logic latchedQ;
  logic startOk, anyTrip, inFault, enterFault, releaseNow;

  assign startOk    = vddAboveOn && vddAboveAc && lineOk;
  assign anyTrip    = |tripVec;
  assign inFault    = (state == ST_FAULT_HI) || (state == ST_PROT_LOW) ||
                      (state == ST_PROT_CHG);
  assign enterFault = ((state == ST_STARTUP) || (state == ST_RUN)) && anyTrip;
  assign releaseNow = inFault && !vddAboveRelease;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_STARTUP: begin
        if (anyTrip)      nextState = ST_FAULT_HI;
        else if (startOk) nextState = ST_RUN;
      end
      ST_RUN: begin
        if (anyTrip)                      nextState = ST_FAULT_HI;
        else if (!vddAboveUvlo || !lineOk) nextState = ST_STARTUP;
      end
      ST_FAULT_HI: begin
        if (!vddAboveRelease)  nextState = ST_STARTUP;
        else if (!vddAboveOff) nextState = ST_PROT_LOW;
      end
      ST_PROT_LOW: begin
        if (!vddAboveRelease)      nextState = ST_STARTUP;
        else if (!vddAboveRestart) nextState = ST_PROT_CHG;
      end
      ST_PROT_CHG: begin
        if (!vddAboveRelease) nextState = ST_STARTUP;
        else if (vddAboveOn) begin
          if (latchedQ)     nextState = ST_PROT_LOW;
          else if (startOk) nextState = ST_RUN;
          else              nextState = ST_STARTUP;
        end
      end
      default: nextState = ST_STARTUP;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_STARTUP;
      faultQ   <= '0;
      latchedQ <= 1'b0;
    end else begin
      state <= nextState;
      if (enterFault) begin
        faultQ   <= tripVec;
        latchedQ <= (|tripVec[NFAULT-1:1]) ||
                    (tripVec[F_OVERLOAD] && latchOverload);
      end else if (releaseNow) begin
        faultQ   <= '0;
        latchedQ <= 1'b0;
      end else if (state == ST_FAULT_HI && !vddAboveOff && !latchedQ) begin
        faultQ <= '0;
      end
    end
  end

  assign pwmRun             = (state == ST_RUN);
  assign hvStartEn          = ((state == ST_STARTUP) && !vddAboveOn) ||
                              (state == ST_PROT_CHG);
  assign protMode           = (state == ST_PROT_LOW) || (state == ST_PROT_CHG);
  assign faultStatus        = faultQ;
  assign strobe.overloadArm = (state == ST_RUN);
  assign strobe.clearAll    = inFault;

  assert_start_gate_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwmRun) |-> $past(vddAboveOn && vddAboveAc && lineOk));
  assert_uvlo_stop_R2: assert property (@(posedge clk) disable iff (!rstN)
    (pwmRun && !vddAboveUvlo) |=> !pwmRun);
  assert_fault_stop_R5: assert property (@(posedge clk) disable iff (!rstN)
    (pwmRun && anyTrip) |=> (!pwmRun && faultStatus != '0));
  assert_latch_no_resume_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(latchedQ) && $past(vddAboveRelease) && $past(protMode)) |-> !pwmRun);
  assert_release_R10: assert property (@(posedge clk) disable iff (!rstN)
    (protMode && !vddAboveRelease) |=> (faultStatus == '0 && !protMode));
endmodule

// File: rtl/supply_supervisor.sv
module supply_supervisor
  import supv_pkg::*;
#(
  parameter int unsigned OVERLOAD_TICKS = 57500,
  parameter int unsigned OVERVOLT_TICKS = 205,
  parameter int unsigned TEMP_TICKS     = 14500,
  parameter int unsigned EXTLATCH_TICKS = 185
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       vddAboveOn,
  input  logic       vddAboveOff,
  input  logic       vddAboveRestart,
  input  logic       vddAboveUvlo,
  input  logic       vddAboveRelease,
  input  logic       vddAboveAc,
  input  logic       vddOverVolt,
  input  logic       lineOk,
  input  logic       fbOverload,
  input  logic       rtBelowTemp,
  input  logic       rtBelowLatch,
  input  logic       latchOverload,
  output logic       hvStartEn,
  output logic       pwmRun,
  output logic       protMode,
  output logic [3:0] faultStatus
);
  logic [NFAULT-1:0] condVec, tripVec;
  strobe_t strobe;

  assign condVec = {rtBelowLatch, rtBelowTemp, vddOverVolt, fbOverload};

  supv_timers #(
    .OVERLOAD_TICKS(OVERLOAD_TICKS),
    .OVERVOLT_TICKS(OVERVOLT_TICKS),
    .TEMP_TICKS    (TEMP_TICKS),
    .EXTLATCH_TICKS(EXTLATCH_TICKS)
  ) u_timers (
    .clk    (clk),
    .rstN   (rstN),
    .tick   (tick),
    .condVec(condVec),
    .strobe (strobe),
    .tripVec(tripVec)
  );

  supv_ctrl u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .vddAboveOn     (vddAboveOn),
    .vddAboveOff    (vddAboveOff),
    .vddAboveRestart(vddAboveRestart),
    .vddAboveUvlo   (vddAboveUvlo),
    .vddAboveRelease(vddAboveRelease),
    .vddAboveAc     (vddAboveAc),
    .lineOk         (lineOk),
    .latchOverload  (latchOverload),
    .tripVec        (tripVec),
    .strobe         (strobe),
    .hvStartEn      (hvStartEn),
    .pwmRun         (pwmRun),
    .protMode       (protMode),
    .faultStatus    (faultStatus)
  );
endmodule

// File: tb/supply_supervisor_test.sv
`timescale 1ns/1ps
module supply_supervisor_test;
  localparam int L_OL = 6, L_OV = 3, L_TP = 5, L_EX = 2;

  logic clk = 1'b0;
  logic rstN, tick;
  logic vddAboveOn, vddAboveOff, vddAboveRestart, vddAboveUvlo, vddAboveRelease;
  logic vddAboveAc, vddOverVolt, lineOk, fbOverload, rtBelowTemp, rtBelowLatch;
  logic latchOverload;
  logic hvStartEn, pwmRun, protMode;
  logic [3:0] faultStatus;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  supply_supervisor #(
    .OVERLOAD_TICKS(L_OL), .OVERVOLT_TICKS(L_OV),
    .TEMP_TICKS(L_TP), .EXTLATCH_TICKS(L_EX)
  ) uut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // supply level in tenths of a volt
  task automatic setVdd(input int v);
    vddAboveOn      = (v >= 170);
    vddAboveOff     = (v >= 110);
    vddAboveRestart = (v >= 70);
    vddAboveUvlo    = (v >= 65);
    vddAboveRelease = (v >= 40);
    vddAboveAc      = (v >= 95);
    vddOverVolt     = (v > 245);
  endtask

  task automatic doReset();
    rstN = 1'b0; tick = 1'b1; lineOk = 1'b1; latchOverload = 1'b0;
    fbOverload = 1'b0; rtBelowTemp = 1'b0; rtBelowLatch = 1'b0;
    setVdd(0);
    step(2);
    rstN = 1'b1;
    step(1);
  endtask

  task automatic runFault(input int k, input bit cfg);
    int lim;
    bit latched;
    string tag;
    lim = (k == 0) ? L_OL : (k == 1) ? L_OV : (k == 2) ? L_TP : L_EX;
    latched = (k != 0) || cfg;
    tag = $sformatf("k%0d cfg%0d", k, cfg);
    doReset();
    latchOverload = cfg;
    setVdd(175); step(1);
    chk({"R1 start pwm ", tag}, pwmRun, 1);
    case (k)
      0: fbOverload = 1'b1;
      1: setVdd(250);
      2: rtBelowTemp = 1'b1;
      default: begin rtBelowTemp = 1'b1; rtBelowLatch = 1'b1; end
    endcase
    step(lim);
    chk({"R4 still running at limit ", tag}, pwmRun, 1);
    step(1);
    chk({"R5 stop ", tag}, pwmRun, 0);
    chk({"R5 status ", tag}, faultStatus, 1 << k);
    chk({"R5 hv off ", tag}, hvStartEn, 0);
    fbOverload = 1'b0; rtBelowTemp = 1'b0; rtBelowLatch = 1'b0;
    setVdd(150); step(2);
    chk({"R5 no prot above 11 ", tag}, protMode, 0);
    setVdd(100); step(1);
    chk({"R6 prot ", tag}, protMode, 1);
    chk({"R6 R11 status ", tag}, faultStatus, latched ? (1 << k) : 0);
    setVdd(68); step(1);
    chk({"R7 hv on ", tag}, hvStartEn, 1);
    setVdd(175); step(1);
    if (!latched) begin
      chk({"R8 resume ", tag}, pwmRun, 1);
      chk({"R8 prot off ", tag}, protMode, 0);
      setVdd(60); step(1);
      chk({"R2 stop ", tag}, pwmRun, 0);
    end else begin
      chk({"R9 no resume ", tag}, pwmRun, 0);
      chk({"R7 hv off ", tag}, hvStartEn, 0);
      chk({"R9 prot kept ", tag}, protMode, 1);
      chk({"R9 status kept ", tag}, faultStatus, 1 << k);
      setVdd(68); step(1);
      chk({"R9 recharge ", tag}, hvStartEn, 1);
      setVdd(175); step(1);
      chk({"R9 second cycle ", tag}, pwmRun, 0);
      setVdd(35); step(1);
      chk({"R10 status clear ", tag}, faultStatus, 0);
      chk({"R10 prot off ", tag}, protMode, 0);
      chk({"R10 hv startup ", tag}, hvStartEn, 1);
      setVdd(175); step(1);
      chk({"R10 restart ", tag}, pwmRun, 1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    doReset();
    chk("R1 reset hv", hvStartEn, 1);
    chk("R1 reset pwm", pwmRun, 0);
    chk("R1 reset prot", protMode, 0);
    chk("R1 reset status", faultStatus, 0);

    for (int k = 0; k < 4; k++)
      for (int c = 0; c < 2; c++)
        runFault(k, c[0]);

    // R2: no-fault lockout sweep
    doReset();
    setVdd(175); step(1);
    for (int v = 170; v >= 65; v -= 5) begin
      setVdd(v); step(1);
      chk($sformatf("R2 running at %0d", v), pwmRun, 1);
    end
    setVdd(60); step(1);
    chk("R2 below lockout pwm", pwmRun, 0);
    chk("R2 below lockout hv", hvStartEn, 1);

    // R1: start gating by line and supply brown-in level
    doReset();
    lineOk = 1'b0; setVdd(175); step(2);
    chk("R1 line low no start", pwmRun, 0);
    chk("R1 hv off at 17", hvStartEn, 0);
    lineOk = 1'b1; vddAboveAc = 1'b0; step(1);
    chk("R1 ac low no start", pwmRun, 0);
    vddAboveAc = 1'b1; step(1);
    chk("R1 gated start", pwmRun, 1);

    // R3: brownout while running
    lineOk = 1'b0; step(1);
    chk("R3 brownout stop", pwmRun, 0);
    setVdd(150); step(1);
    chk("R3 back in startup", hvStartEn, 1);

    // R4: debounce restart on condition loss
    doReset();
    setVdd(175); step(1);
    rtBelowTemp = 1'b1; step(L_TP - 1);
    rtBelowTemp = 1'b0; step(1);
    rtBelowTemp = 1'b1; step(L_TP);
    chk("R4 restarted timer not expired", pwmRun, 1);
    step(1);
    chk("R4 restarted timer expiry", pwmRun, 0);
    chk("R4 restart status", faultStatus, 4);

    // R4: no counting without tick
    doReset();
    setVdd(175); step(1);
    tick = 1'b0; fbOverload = 1'b1; step(20);
    chk("R4 tick low no trip", pwmRun, 1);
    tick = 1'b1; step(L_OL);
    chk("R4 tick resumes not yet", pwmRun, 1);
    step(1);
    chk("R4 tick resumes trip", pwmRun, 0);
    chk("R4 tick status", faultStatus, 1);

    // R4: overload timer counts only while switching
    doReset();
    setVdd(150); fbOverload = 1'b1; step(10);
    chk("R4 overload idle in startup", faultStatus, 0);
    setVdd(175); step(1);
    chk("R4 overload start", pwmRun, 1);
    step(L_OL);
    chk("R4 overload armed late", pwmRun, 1);
    step(1);
    chk("R4 overload fires", pwmRun, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule